// File: doc/BRIEF.md
# Time-Ordered Record Merger

This block takes several streams of timestamped records and produces a single stream in which timestamps never go backwards. Every input stream is assumed to be sorted on its own already. The block keeps one head record for each input. It forwards the head with the smallest timestamp only when it knows that no input can still deliver something earlier. That is the case when every input either holds a head record or has declared through its idle line that no more data will come.

One instance can act as a collator that combines the streams of several cards. A second instance can then combine the outputs of two or more collators into the final ordered stream. Each output record carries the index of the input it came from. All inputs and the output use a valid/ready handshake. When the inputs keep their heads filled and the output is not stalled, one record leaves the block per clock cycle.

Top module: `tsm_merge`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and every `in_ready` bit is 1.
- R2: If each input's timestamps are non-decreasing, the output timestamps are non-decreasing across all inputs.
- R3: When several eligible heads share the smallest timestamp, the head of the lowest-numbered input is forwarded first.
- R4: `out_tag` equals the index of the input that supplied the record, and `out_ts` and `out_payload` equal the values that were accepted on that input.
- R5: No record is forwarded while any input has no head record and its `in_idle` bit is 0.
- R6: An input that has no head and has `in_idle` at 1 does not hold back the records of the other inputs.
- R7: Every accepted record appears at the output exactly once. No record is lost and none is duplicated.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output record and `out_valid` stay unchanged.
- R9: When every input keeps a head available and `out_ready` stays at 1, one record is forwarded every cycle with no bubbles.
- R10: An input's `in_ready` is 1 when its head slot is empty or its head is forwarded in the same cycle; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Per-input record valid |
| in_ready | output | N_IN | Per-input ready to accept |
| in_ts | input | N_IN x TS_W | Per-input record timestamp |
| in_payload | input | N_IN x PL_W | Per-input record payload |
| in_idle | input | N_IN | Per-input flag: no further records will arrive |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream ready |
| out_ts | output | TS_W | Output timestamp |
| out_payload | output | PL_W | Output payload |
| out_tag | output | $clog2(N_IN) | Index of the source input |

## Verification
The bench builds the block with `N_IN=4`, `TS_W=12` and `PL_W=16`. This keeps every timestamp in a small range, so the complete expected merge order can be computed by sweeping all timestamp values and, within each value, the inputs in index order. The sweep covers four stream shapes: interleaved timestamps, timestamps fully tied across inputs, runs of duplicates inside each stream, and disjoint blocks with one input idle from the start. These shapes are combined with input bubbles and output stalls. A directed sequence then shows that an empty input which is not idle blocks the output, and that raising its idle line releases the output.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // Default geometry of one merger instance.
    localparam int TSM_N_IN_DEF = 4;
    localparam int TSM_TS_W_DEF = 48;
    localparam int TSM_PL_W_DEF = 32;

    // Width of a source index; at least one bit.
    function automatic int tsm_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsm_head_slot.sv
// One-entry head register for an input stream. It refills in the same
// cycle its head is forwarded, which sustains one record per cycle.
module tsm_head_slot #(
    parameter int W = 80
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic         head_vld,
    output logic [W-1:0] head_data
);
    logic full_q;
    logic [W-1:0] data_q;
    logic take;

    assign in_ready  = !full_q || pop;
    assign take      = in_valid && in_ready;
    assign head_vld  = full_q;
    assign head_data = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (take) begin
                full_q <= 1'b1;
                data_q <= in_data;
            end else if (pop) begin
                full_q <= 1'b0;
            end
        end
    end

    // A forwarded head frees the slot unless a new record replaces it.
    assert_pop_frees_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && !in_valid) |=> !head_vld);

endmodule

// File: rtl/tsm_pick.sv
// Chooses the smallest head timestamp. Ties go to the lower index. A head
// is released only when every input has a head or is marked idle.
module tsm_pick #(
    parameter int N     = 4,
    parameter int TS_W  = 48,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]           head_vld,
    input  logic [N-1:0][TS_W-1:0] head_ts,
    input  logic [N-1:0]           idle,
    input  logic                   can_load,
    output logic                   go,
    output logic [IDX_W-1:0]       sel,
    output logic [N-1:0]           pop
);
    logic             found;
    logic [IDX_W-1:0] best;
    logic             settled;

    always_comb begin
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (head_vld[i] && (!found || (head_ts[i] < head_ts[best]))) begin
                best  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign settled = &(head_vld | idle);
    assign go      = found && settled && can_load;
    assign sel     = best;
    assign pop     = go ? (N'(1) << best) : '0;

endmodule

// File: rtl/tsm_out_stage.sv
// Registered output stage that holds its word while the output is stalled.
module tsm_out_stage #(
    parameter int W = 82
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         can_load,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);
    logic vld_q;
    logic [W-1:0] word_q;

    assign can_load  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign dout      = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            word_q <= '0;
        end else if (can_load) begin
            vld_q <= load;
            if (load) word_q <= din;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(dout)));

endmodule

// File: rtl/tsm_merge.sv
module tsm_merge
    import tsm_pkg::*;
#(
    parameter int N_IN  = TSM_N_IN_DEF,
    parameter int TS_W  = TSM_TS_W_DEF,
    parameter int PL_W  = TSM_PL_W_DEF,
    parameter int IDX_W = tsm_idx_w(N_IN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_IN-1:0]            in_valid,
    output logic [N_IN-1:0]            in_ready,
    input  logic [N_IN-1:0][TS_W-1:0]  in_ts,
    input  logic [N_IN-1:0][PL_W-1:0]  in_payload,
    input  logic [N_IN-1:0]            in_idle,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [TS_W-1:0]            out_ts,
    output logic [PL_W-1:0]            out_payload,
    output logic [IDX_W-1:0]           out_tag
);
    localparam int REC_W = TS_W + PL_W;
    localparam int OUT_W = REC_W + IDX_W;

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic [PL_W-1:0] pl;
    } rec_t;

    typedef struct packed {
        logic [IDX_W-1:0] tag;
        rec_t             rec;
    } out_word_t;

    rec_t [N_IN-1:0]            head;
    logic [N_IN-1:0]            head_vld;
    logic [N_IN-1:0][TS_W-1:0]  head_ts;
    logic [N_IN-1:0]            pop;
    logic                       go;
    logic [IDX_W-1:0]           sel;
    logic                       can_load;
    out_word_t                  nxt_word;
    out_word_t                  cur_word;

    for (genvar g = 0; g < N_IN; g++) begin : g_slot
        rec_t in_rec;
        assign in_rec.ts = in_ts[g];
        assign in_rec.pl = in_payload[g];

        tsm_head_slot #(.W(REC_W)) slot_i (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[g]),
            .in_data   (in_rec),
            .in_ready  (in_ready[g]),
            .pop       (pop[g]),
            .head_vld  (head_vld[g]),
            .head_data (head[g])
        );
        assign head_ts[g] = head[g].ts;
    end

    tsm_pick #(.N(N_IN), .TS_W(TS_W), .IDX_W(IDX_W)) pick_i (
        .head_vld (head_vld),
        .head_ts  (head_ts),
        .idle     (in_idle),
        .can_load (can_load),
        .go       (go),
        .sel      (sel),
        .pop      (pop)
    );

    assign nxt_word.tag = sel;
    assign nxt_word.rec = head[sel];

    tsm_out_stage #(.W(OUT_W)) out_i (
        .clk       (clk),
        .rst       (rst),
        .load      (go),
        .din       (nxt_word),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dout      (cur_word)
    );

    assign out_ts      = cur_word.rec.ts;
    assign out_payload = cur_word.rec.pl;
    assign out_tag     = cur_word.tag;

    // At most one head leaves per cycle, so nothing is duplicated.
    assert_single_pop_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop));

    // An empty input that is not idle blocks all forwarding.
    assert_block_R5: assert property (@(posedge clk) disable iff (rst)
        (|(~head_vld & ~in_idle)) |-> (pop == '0));

    // With every input settled and room at the output, a head must leave.
    assert_progress_R6: assert property (@(posedge clk) disable iff (rst)
        ((&(head_vld | in_idle)) && (|head_vld) && (!out_valid || out_ready))
            |-> (pop != '0));

endmodule

// File: tb/tsm_merge_tb.sv
module tsm_merge_tb_top;
    localparam int N    = 4;
    localparam int TSW  = 12;
    localparam int PLW  = 16;
    localparam int IW   = 2;
    localparam int NREC = 12;
    localparam int MAXE = N * NREC;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [N-1:0]            in_valid = '0;
    logic [N-1:0]            in_ready;
    logic [N-1:0][TSW-1:0]   in_ts = '0;
    logic [N-1:0][PLW-1:0]   in_payload = '0;
    logic [N-1:0]            in_idle = '0;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic [TSW-1:0]          out_ts;
    logic [PLW-1:0]          out_payload;
    logic [IW-1:0]           out_tag;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    tsm_merge #(.N_IN(N), .TS_W(TSW), .PL_W(PLW)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_ts(in_ts), .in_payload(in_payload), .in_idle(in_idle),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ts(out_ts), .out_payload(out_payload), .out_tag(out_tag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ts_of(input int p, input int i, input int k);
        case (p)
            0: return k * 4 + i;
            1: return k * 2;
            2: return (k / 3) * 5 + (i % 2);
            default: return i * 40 + k;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = '0; in_idle = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == '1, "R1 in_ready", in_ready, 15);
    endtask

    int exp_ts [MAXE];
    int exp_pl [MAXE];
    int exp_tag[MAXE];

    task automatic run_pattern(input int p);
        int cnt[N];
        int ptr[N];
        bit fired[N];
        int total, got, cyc, first_c, last_c, prev_ts;
        bit hold;
        logic [TSW-1:0] h_ts;
        logic [PLW-1:0] h_pl;
        logic [IW-1:0]  h_tag;
        total = 0;
        for (int i = 0; i < N; i++) begin
            cnt[i] = (p == 3 && i == 3) ? 0 : NREC;
            ptr[i] = 0; fired[i] = 1'b0;
            total += cnt[i];
        end
        // Expected order: ascending timestamp, then ascending input index.
        begin
            int e = 0;
            for (int v = 0; v < 128; v++)
                for (int i = 0; i < N; i++)
                    for (int k = 0; k < cnt[i]; k++)
                        if (ts_of(p, i, k) == v) begin
                            exp_ts[e] = v; exp_pl[e] = i * 256 + k; exp_tag[e] = i; e++;
                        end
        end
        do_reset();
        got = 0; cyc = 0; first_c = -1; last_c = -1; prev_ts = 0; hold = 1'b0;
        h_ts = '0; h_pl = '0; h_tag = '0;
        while (got < total && cyc < 3000) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (fired[i]) begin in_valid[i] = 1'b0; fired[i] = 1'b0; end
                if (!in_valid[i] && ptr[i] < cnt[i] &&
                    ((p % 2 == 0) || ((cyc * 3 + i * 5 + p) % 4 != 0))) begin
                    in_valid[i]   = 1'b1;
                    in_ts[i]      = TSW'(ts_of(p, i, ptr[i]));
                    in_payload[i] = PLW'(i * 256 + ptr[i]);
                end
                in_idle[i] = (ptr[i] == cnt[i]);
            end
            out_ready = (p < 2) ? 1'b1 : (((cyc * 5 + p) % 3) != 0);
            #3;
            if (hold) begin
                check(out_valid && out_ts == h_ts && out_payload == h_pl && out_tag == h_tag,
                      "R8 stalled output held", out_payload, h_pl);
                hold = 1'b0;
            end
            for (int i = 0; i < N; i++)
                if (in_valid[i] && in_ready[i]) begin ptr[i]++; fired[i] = 1'b1; end
            if (out_valid && out_ready) begin
                check(out_ts == TSW'(exp_ts[got]), "R2/R3 timestamp order", out_ts, exp_ts[got]);
                check(out_payload == PLW'(exp_pl[got]), "R3/R7 record identity", out_payload, exp_pl[got]);
                check(out_tag == IW'(exp_tag[got]), "R4 source tag", out_tag, exp_tag[got]);
                if (got > 0)
                    check(int'(out_ts) >= prev_ts, "R2 non-decreasing", out_ts, prev_ts);
                prev_ts = int'(out_ts);
                if (first_c < 0) first_c = cyc;
                last_c = cyc;
                got++;
            end else if (out_valid) begin
                hold = 1'b1; h_ts = out_ts; h_pl = out_payload; h_tag = out_tag;
            end
            cyc++;
        end
        check(got == total, "R7 record count (watchdog)", got, total);
        // Nothing beyond the expected records may follow.
        @(negedge clk);
        for (int i = 0; i < N; i++) in_idle[i] = 1'b1;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R7 no extra record", out_valid, 0);
        if (p == 0)
            check(last_c - first_c == total - 1, "R9 one record per cycle", last_c - first_c, total - 1);
        in_valid = '0;
    endtask

    task automatic run_blocking();
        do_reset();
        @(negedge clk);
        in_valid[0] = 1'b1; in_ts[0] = TSW'(5); in_payload[0] = PLW'(16'h0A0A);
        out_ready = 1'b1;
        #3;
        check(in_ready[0] == 1'b1, "R10 empty slot ready", in_ready[0], 1);
        @(negedge clk);
        in_valid[0] = 1'b0;
        repeat (4) @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R5 empty non-idle input blocks", out_valid, 0);
        check(in_ready[0] == 1'b0, "R10 full slot not ready", in_ready[0], 0);
        @(negedge clk);
        in_idle[1] = 1'b1; in_idle[2] = 1'b1; in_idle[3] = 1'b1;
        #3;
        check(in_ready[0] == 1'b1, "R10 ready while head leaves", in_ready[0], 1);
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R6 idle inputs release output", out_valid, 1);
        check(out_ts == TSW'(5) && out_tag == IW'(0), "R6 released record", out_ts, 5);
        check(out_payload == PLW'(16'h0A0A), "R4 payload carried", out_payload, 16'h0A0A);
        in_idle = '0;
    endtask

    initial begin
        run_blocking();
        for (int p = 0; p < 4; p++) run_pattern(p);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule